// File: doc/BRIEF.md
# L1A Rate Throttle

This block caps the average trigger rate with a leaky bucket. Each accepted level-one trigger (L1A) puts one unit into a small saturating level counter. A leak tick removes one unit. An internal prescaler makes the tick by dividing the clock, and it is set so that one tick falls every 10 µs. With the default thresholds the bucket allows about 30 triggers in any 300 µs stretch, which is 12000 bunch crossings.

When the level reaches the upper threshold, a busy flag asserts toward the trigger throttling system. The flag stays high until the level has drained to the lower threshold. This hysteresis stops busy from toggling on every trigger near the limit. A 32-bit counter records how many times the throttle has engaged. A configuration enable turns the function off. While the enable is low, busy is held low and the bucket is held empty.

Top module: `trig_rate_throttle`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `busy_o` is 0 and `engage_count_o` is 0.
- R2: With `enable_i` high, an L1A on a cycle with no leak tick raises the 5-bit level by one. `busy_o` goes to 1 on the clock edge after the edge that brings the level to 30 (`SET_LVL`).
- R3: The leak tick fires on every `TICK_DIV`-th clock edge after reset. The first one falls on edge number `TICK_DIV`. A tick with no L1A lowers the level by one.
- R4: An L1A and a leak tick on the same edge leave the level unchanged.
- R5: The level saturates at 31. Further L1As leave it at 31, so the drain before release takes one extra tick.
- R6: The level never goes below 0. Ticks while the bucket is empty are lost, and after that exactly 30 net L1As are needed to assert busy.
- R7: Once `busy_o` is 1, it stays 1 while the level is above 15 (`CLR_LVL`). It goes to 0 on the edge after the edge at which the level is 15 or less.
- R8: While `enable_i` is 0, `busy_o` is 0 from the next edge, the level is held at 0 and `engage_count_o` does not change.
- R9: `engage_count_o` rises by exactly one on each edge at which `busy_o` goes from 0 to 1. It holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| l1a_i | input | 1 | One-cycle trigger accept pulse |
| enable_i | input | 1 | Throttle enable; 0 forces busy low and empties the bucket |
| busy_o | output | 1 | Throttle busy toward the trigger throttling system |
| engage_count_o | output | 32 | Number of times busy has asserted |

## Verification
The hardest situation to reach from the ports is a trigger that lands exactly on a leak-tick edge. Close behind it are the exact threshold crossings that follow a floor or saturation event. The bench keeps its own prescaler phase in a behavioural model, so it knows one cycle ahead whether the next edge carries a tick. It uses this to place L1As on tick edges on purpose, and to count only the non-tick L1As while it fills an empty bucket to exactly 30. Busy and the engage count are compared with the model on every clock. This covers bursts that saturate the level, long idle periods that hit the floor, disabling while busy, and a pseudo-random mix.

// File: rtl/throttle_pkg.sv
// Package: shared constants for the L1A rate throttle.
// Assumes: none; only defaults live here, every module takes parameters.
package throttle_pkg;
    localparam int DEF_LEVEL_W  = 5;
    localparam int DEF_SET_LVL  = 30;
    localparam int DEF_CLR_LVL  = 15;
    localparam int DEF_ENG_W    = 32;
    localparam int DEF_TICK_DIV = 400;

    typedef enum logic [1:0] {
        LV_HOLD = 2'd0,
        LV_UP   = 2'd1,
        LV_DOWN = 2'd2
    } lvl_step_e;
endpackage

// File: rtl/thr_tick_gen.sv
// Module: leak tick prescaler.
// Produces a one-cycle pulse on every DIV-th clock edge after reset.
// Assumes: DIV >= 1; free-running, unaffected by the throttle enable.
module thr_tick_gen #(
    parameter int DIV = 400
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] pcnt_q;

    // Decode the terminal count as the tick.
    always_comb begin
        tick_o = (pcnt_q == LAST);
    end

    // Advance the prescaler, wrapping at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (tick_o) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/thr_leaky_level.sv
// Module: saturating leaky-bucket level.
// L1A adds one, tick removes one, both together cancel; clamps at 0 and max.
// Assumes: clear_i held high empties the bucket and masks both inputs.
module thr_leaky_level #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         up_i,
    input  logic         down_i,
    output logic [W-1:0] level_o
);
    import throttle_pkg::*;

    localparam logic [W-1:0] TOP = '1;

    lvl_step_e     step;
    logic [W-1:0]  level_q;

    // Pick the step direction, suppressing it at either end of the range.
    always_comb begin
        step = LV_HOLD;
        if (up_i && !down_i && level_q != TOP) begin
            step = LV_UP;
        end else if (down_i && !up_i && level_q != '0) begin
            step = LV_DOWN;
        end
    end

    // Update the level register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            level_q <= '0;
        end else begin
            case (step)
                LV_UP:   level_q <= level_q + W'(1);
                LV_DOWN: level_q <= level_q - W'(1);
                default: level_q <= level_q;
            endcase
        end
    end

    assign level_o = level_q;
endmodule

// File: rtl/thr_hysteresis.sv
// Module: busy flag with set/clear thresholds and an engage counter.
// Busy sets when level >= SET, clears when level <= CLR, holds between.
// Assumes: SET > CLR; the engage counter wraps and is cleared only by reset.
module thr_hysteresis #(
    parameter int W     = 5,
    parameter int SET   = 30,
    parameter int CLR   = 15,
    parameter int ENG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [W-1:0]     level_i,
    output logic             busy_o,
    output logic [ENG_W-1:0] engage_o
);
    localparam logic [W-1:0] SET_V = W'(SET);
    localparam logic [W-1:0] CLR_V = W'(CLR);

    logic             busy_q;
    logic [ENG_W-1:0] engage_q;
    logic             engage_now;

    // An engagement is an idle-to-busy transition while enabled.
    always_comb begin
        engage_now = enable_i && !busy_q && (level_i >= SET_V);
    end

    // Track the busy state with hysteresis.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i) begin
            busy_q <= 1'b0;
        end else if (level_i >= SET_V) begin
            busy_q <= 1'b1;
        end else if (level_i <= CLR_V) begin
            busy_q <= 1'b0;
        end
    end

    // Count engagements.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            engage_q <= '0;
        end else if (engage_now) begin
            engage_q <= engage_q + ENG_W'(1);
        end
    end

    assign busy_o   = busy_q;
    assign engage_o = engage_q;
endmodule

// File: rtl/trig_rate_throttle.sv
// Module: L1A rate throttle top.
// Connects the prescaler, the leaky level and the hysteresis stage.
// Assumes: l1a_i is a one-cycle pulse per accepted trigger, synchronous to clk.
module trig_rate_throttle #(
    parameter int TICK_DIV = throttle_pkg::DEF_TICK_DIV,
    parameter int LEVEL_W  = throttle_pkg::DEF_LEVEL_W,
    parameter int SET_LVL  = throttle_pkg::DEF_SET_LVL,
    parameter int CLR_LVL  = throttle_pkg::DEF_CLR_LVL,
    parameter int ENG_W    = throttle_pkg::DEF_ENG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             l1a_i,
    input  logic             enable_i,
    output logic             busy_o,
    output logic [ENG_W-1:0] engage_count_o
);
    logic               leak_tick;
    logic [LEVEL_W-1:0] level_q;

    thr_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (leak_tick)
    );

    thr_leaky_level #(.W(LEVEL_W)) u_level (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (!enable_i),
        .up_i    (l1a_i),
        .down_i  (leak_tick),
        .level_o (level_q)
    );

    thr_hysteresis #(
        .W     (LEVEL_W),
        .SET   (SET_LVL),
        .CLR   (CLR_LVL),
        .ENG_W (ENG_W)
    ) u_hyst (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (enable_i),
        .level_i  (level_q),
        .busy_o   (busy_o),
        .engage_o (engage_count_o)
    );
endmodule

// File: rtl/trig_rate_throttle_chk.sv
// Module: assertion checker bound to trig_rate_throttle.
// Assumes: observes the tick and level nets between the submodules.
module trig_rate_throttle_chk #(
    parameter int LEVEL_W = 5,
    parameter int SET_LVL = 30,
    parameter int CLR_LVL = 15,
    parameter int ENG_W   = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               l1a,
    input logic               enable,
    input logic               tick,
    input logic [LEVEL_W-1:0] level,
    input logic               busy,
    input logic [ENG_W-1:0]   engage
);
    localparam logic [LEVEL_W-1:0] TOP   = '1;
    localparam logic [LEVEL_W-1:0] SET_V = LEVEL_W'(SET_LVL);
    localparam logic [LEVEL_W-1:0] CLR_V = LEVEL_W'(CLR_LVL);

    p_busy_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && level >= SET_V) |=> busy);

    p_cancel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && l1a && tick) |=> $stable(level));

    p_saturate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && level == TOP && l1a && !tick) |=> (level == TOP));

    p_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && level == '0 && tick && !l1a) |=> (level == '0));

    p_hold_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && busy && level > CLR_V) |=> busy);

    p_disable_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!busy && level == '0));

    p_engage_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (engage == $past(engage) + ENG_W'(1)));

    p_engage_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(busy) |-> $stable(engage));
endmodule

bind trig_rate_throttle trig_rate_throttle_chk #(
    .LEVEL_W (LEVEL_W),
    .SET_LVL (SET_LVL),
    .CLR_LVL (CLR_LVL),
    .ENG_W   (ENG_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .l1a    (l1a_i),
    .enable (enable_i),
    .tick   (leak_tick),
    .level  (level_q),
    .busy   (busy_o),
    .engage (engage_count_o)
);

// File: tb/tb_trig_rate_throttle.sv
// Bench: behavioural model of the throttle compared on every clock,
// plus directed checks at the threshold corners.
module tb_trig_rate_throttle;
    localparam int DIV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        l1a = 1'b0;
    logic        en = 1'b0;
    logic        busy;
    logic [31:0] eng;

    int n_chk = 0;
    int n_bad = 0;

    // Model state.
    int  m_pc = 0;
    int  m_lvl = 0;
    bit  m_busy = 0;
    longint m_eng = 0;

    always #2 clk = ~clk;

    trig_rate_throttle #(.TICK_DIV(DIV)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .l1a_i          (l1a),
        .enable_i       (en),
        .busy_o         (busy),
        .engage_count_o (eng)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: advances on every rising edge.
    always @(posedge clk) begin
        bit t;
        if (!rst_n) begin
            m_pc = 0; m_lvl = 0; m_busy = 0; m_eng = 0;
        end else begin
            t = (m_pc == DIV - 1);
            m_pc = t ? 0 : m_pc + 1;
            if (!en) begin
                m_busy = 0;
                m_lvl = 0;
            end else begin
                if (!m_busy && m_lvl >= 30) m_eng = (m_eng + 1) % 64'h1_0000_0000;
                if (m_lvl >= 30) m_busy = 1;
                else if (m_lvl <= 15) m_busy = 0;
                if (l1a && !t) m_lvl = (m_lvl < 31) ? m_lvl + 1 : 31;
                else if (t && !l1a) m_lvl = (m_lvl > 0) ? m_lvl - 1 : 0;
            end
        end
    end

    // Every-clock comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(busy == m_busy, "R7 busy vs model", busy, m_busy);
            check(eng == m_eng[31:0], "R9 engage vs model", eng, m_eng);
        end
    end

    // One stimulus cycle; returns whether the coming edge carries a tick.
    task automatic cyc(input bit a, input bit e, output bit will_tick);
        @(negedge clk);
        will_tick = rst_n && (m_pc == DIV - 1);
        l1a = a;
        en = e;
    endtask

    task automatic run(input bit a, input bit e, input int n);
        bit wt;
        for (int i = 0; i < n; i++) cyc(a, e, wt);
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit wt;
        int n;
        longint e0;
        logic [7:0] lfsr;

        // R1: reset state.
        repeat (4) @(negedge clk);
        check(busy == 0, "R1 busy in reset", busy, 0);
        check(eng == 0, "R1 engage in reset", eng, 0);
        @(negedge clk); rst_n = 1'b1; en = 1'b1;
        @(negedge clk);
        check(busy == 0, "R1 busy after reset", busy, 0);
        check(eng == 0, "R1 engage after reset", eng, 0);

        // R2/R5: long burst reaches and saturates the level.
        run(1, 1, 60);
        check(busy == 1, "R2 busy after burst", busy, 1);
        check(eng == 1, "R9 one engagement", eng, 1);

        // R3/R7: drain; busy releases only after the level reaches 15.
        run(0, 1, 8 * 12);
        check(busy == 1, "R7 still busy mid-drain", busy, 1);
        run(0, 1, 8 * 10);
        check(busy == 0, "R7 released after drain", busy, 0);

        // R6: empty the bucket, then add exactly 30 net L1As.
        run(0, 1, 400);
        n = 0;
        while (n < 30) begin
            cyc(1, 1, wt);
            if (!wt) n++;
        end
        @(negedge clk);
        check(busy == 0, "R6 busy one edge after level 30", busy, 0);
        cyc(1, 1, wt);
        l1a = 0;
        @(negedge clk);
        check(busy == 1, "R6 busy after exactly 30 net L1A", busy, 1);
        check(eng == 2, "R9 second engagement", eng, 2);
        run(0, 1, 400);

        // R4: L1As only on tick edges cancel out.
        e0 = eng;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            l1a = (m_pc == DIV - 1);
        end
        l1a = 0;
        @(negedge clk);
        check(busy == 0, "R4 no busy from cancelled L1A", busy, 0);
        check(eng == e0, "R4 engage unchanged", eng, e0);

        // R8: disable while busy, then re-enable with an empty bucket.
        run(1, 1, 50);
        check(busy == 1, "R8 busy before disable", busy, 1);
        e0 = eng;
        run(1, 0, 40);
        check(busy == 0, "R8 busy low while disabled", busy, 0);
        check(eng == e0, "R8 engage frozen while disabled", eng, e0);
        run(1, 1, 20);
        check(busy == 0, "R8 bucket emptied by disable", busy, 0);
        run(0, 1, 300);

        // Mixed pseudo-random traffic with occasional disables.
        lfsr = 8'hA5;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cyc(lfsr[1] | lfsr[3], !(lfsr == 8'h11 || (i % 997) < 5), wt);
        end
        run(0, 1, 10);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule